// File: doc/BRIEF.md
# Double-Buffered PWM Comparison Unit

This block runs a free-running reference up-counter in the same way as a PWM channel period counter. It compares that counter against an active comparison value. Whenever the comparison is enabled and the counter equals that value, it raises a match output. Software never writes the active comparison settings directly. It writes a value shadow and a configuration shadow through a single write port. The configuration write commits the most recent value and marks an update as pending.

An update-period counter steps once per counter wrap. The pending settings move into the active registers only on a wrap where the update-period counter has reached the active update period. Settings can therefore be changed while the counter runs without a half-applied comparison. Writing a value alone never changes the active comparison.

Top module: `pwm_cmp_unit`

## Requirements
- R1: The counter `cnt_o` counts up by one per clock from 0. In the cycle where `cnt_o >= period_i`, `period_end_o` is high and the counter returns to 0 on the next clock.
- R2: A write (`wr_en_i` high for one clock) with `wr_sel_i = 0` loads the value shadow from all of `wr_data_i`. With `wr_sel_i = 1` it loads the configuration shadow, where bit 0 is the enable and bits 4:1 are the update period.
- R3: `cmp_val_o` and `cmp_en_o` change only on the clock that ends a period in which `period_end_o` is high and `upd_cnt_o` equals the active update period.
- R4: `match_o` is high in exactly the cycles where `cmp_en_o` is 1 and `cnt_o` equals `cmp_val_o`.
- R5: `upd_cnt_o` increments at each period end and returns to 0 at the period end where it equals the active update period. An update period of 0 transfers at every period end.
- R6: A value write followed by no configuration write never reaches `cmp_val_o`. A later configuration write commits the latest value written.
- R7: When several writes occur between two transfers, the transfer applies the last value and the last configuration that were committed.
- R8: A transfer point that has no configuration write pending since the previous transfer leaves `cmp_val_o` and `cmp_en_o` unchanged.
- R9: With the active enable at 0, `match_o` stays low for every counter value.
- R10: While `rst_ni` is low, `cnt_o`, `upd_cnt_o`, `cmp_val_o`, `cmp_en_o` and `match_o` are 0, and no update is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Last counter value of a period |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0: value shadow, 1: configuration shadow |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Reference counter |
| period_end_o | output | 1 | Counter wraps at the next clock |
| upd_cnt_o | output | UPR_W | Update-period counter |
| cmp_val_o | output | CNT_W | Active comparison value |
| cmp_en_o | output | 1 | Active comparison enable |
| match_o | output | 1 | Comparison match |

## Verification
A wrong update-period count or a lost pending flag shows up as `cmp_val_o` or `cmp_en_o` moving on the wrong wrap, or not moving at all. That error is visible at the latest one update window after the configuration write. A wrong active value shows on `match_o` within one counter period, because every counter value is visited once per period. A counter that misses its wrap shows on `period_end_o` and `cnt_o` in the cycle that follows. The bench compares every port on every cycle against an arithmetic model, across swept periods, update periods and comparison values.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic {
    SEL_VAL = 1'b0,
    SEL_CFG = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/pwm_ref_counter.sv
module pwm_ref_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_end_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= so a period shortened below the live count still wraps
  assign period_end_o = (cnt_q >= period_i);
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (period_end_o) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_upd_timer.sv
module pwm_upd_timer #(
  parameter int UPR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_end_i,
  input  logic [UPR_W-1:0] upr_i,
  output logic [UPR_W-1:0] cnt_o,
  output logic             xfer_o
);
  logic [UPR_W-1:0] cnt_q;

  assign xfer_o = period_end_i && (cnt_q == upr_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (xfer_o)       cnt_q <= '0;
    else if (period_end_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int UPR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  wr_sel_e          wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             xfer_i,
  output logic [CNT_W-1:0] nxt_val_o,
  output logic             nxt_en_o,
  output logic [UPR_W-1:0] nxt_upr_o,
  output logic             pending_o
);
  logic [CNT_W-1:0] val_shadow_q;
  logic [CNT_W-1:0] val_commit_q;
  logic             en_commit_q;
  logic [UPR_W-1:0] upr_commit_q;
  logic             pend_q;
  logic             wr_val, wr_cfg;

  assign wr_val = wr_en_i && (wr_sel_i == SEL_VAL);
  assign wr_cfg = wr_en_i && (wr_sel_i == SEL_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_shadow_q <= '0;
      val_commit_q <= '0;
      en_commit_q  <= 1'b0;
      upr_commit_q <= '0;
      pend_q       <= 1'b0;
    end else begin
      if (wr_val) val_shadow_q <= wr_data_i;
      // config write commits the value shadow together with the config
      if (wr_cfg) begin
        val_commit_q <= val_shadow_q;
        en_commit_q  <= wr_data_i[0];
        upr_commit_q <= wr_data_i[UPR_W:1];
        pend_q       <= 1'b1;
      end else if (xfer_i) begin
        pend_q       <= 1'b0;
      end
    end
  end

  assign nxt_val_o = val_commit_q;
  assign nxt_en_o  = en_commit_q;
  assign nxt_upr_o = upr_commit_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int UPR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_end_o,
  output logic [UPR_W-1:0] upd_cnt_o,
  output logic [CNT_W-1:0] cmp_val_o,
  output logic             cmp_en_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt;
  logic             pend_end;
  logic             xfer;
  logic [CNT_W-1:0] nxt_val;
  logic             nxt_en;
  logic [UPR_W-1:0] nxt_upr;
  logic             pending;
  logic [CNT_W-1:0] act_val_q;
  logic             act_en_q;
  logic [UPR_W-1:0] act_upr_q;
  wr_sel_e          sel;

  assign sel = wr_sel_e'(wr_sel_i);

  pwm_ref_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_i     (period_i),
    .cnt_o        (cnt),
    .period_end_o (pend_end)
  );

  pwm_upd_timer #(.UPR_W(UPR_W)) u_upd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_end_i (pend_end),
    .upr_i        (act_upr_q),
    .cnt_o        (upd_cnt_o),
    .xfer_o       (xfer)
  );

  pwm_cmp_shadow #(.CNT_W(CNT_W), .UPR_W(UPR_W)) u_shd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wr_data_i (wr_data_i),
    .xfer_i    (xfer),
    .nxt_val_o (nxt_val),
    .nxt_en_o  (nxt_en),
    .nxt_upr_o (nxt_upr),
    .pending_o (pending)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_val_q <= '0;
      act_en_q  <= 1'b0;
      act_upr_q <= '0;
    end else if (xfer && pending) begin
      act_val_q <= nxt_val;
      act_en_q  <= nxt_en;
      act_upr_q <= nxt_upr;
    end
  end

  assign cnt_o        = cnt;
  assign period_end_o = pend_end;
  assign cmp_val_o    = act_val_q;
  assign cmp_en_o     = act_en_q;
  assign match_o      = act_en_q && (cnt == act_val_q);
endmodule

// File: rtl/pwm_cmp_unit_chk.sv
module pwm_cmp_unit_chk #(
  parameter int CNT_W = 16,
  parameter int UPR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_o,
  input logic             period_end_o,
  input logic [UPR_W-1:0] upd_cnt_o,
  input logic [CNT_W-1:0] cmp_val_o,
  input logic             cmp_en_o,
  input logic             match_o
);
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> (cnt_o == '0));

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_o |=> (cnt_o == $past(cnt_o) + 1'b1));

  p_hold_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_o |=> ($stable(cmp_val_o) && $stable(cmp_en_o)));

  p_match_eq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (cnt_o == cmp_val_o));

  p_upd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_o |=> $stable(upd_cnt_o));

  p_no_match_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_o |-> !match_o);
endmodule

bind pwm_cmp_unit pwm_cmp_unit_chk #(.CNT_W(CNT_W), .UPR_W(UPR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_o        (cnt_o),
  .period_end_o (period_end_o),
  .upd_cnt_o    (upd_cnt_o),
  .cmp_val_o    (cmp_val_o),
  .cmp_en_o     (cmp_en_o),
  .match_o      (match_o)
);

// File: tb/sim_pwm_cmp_unit.sv
`timescale 1ns/1ps
module sim_pwm_cmp_unit;
  localparam int CNT_W = 16;
  localparam int UPR_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = 16'd3;
  logic             wr_en_i = 1'b0;
  logic             wr_sel_i = 1'b0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic             period_end_o;
  logic [UPR_W-1:0] upd_cnt_o;
  logic [CNT_W-1:0] cmp_val_o;
  logic             cmp_en_o;
  logic             match_o;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  pwm_cmp_unit #(.CNT_W(CNT_W), .UPR_W(UPR_W)) u0 (.*);

  always #2 clk_i = ~clk_i;

  // arithmetic model of the requirements
  logic [CNT_W-1:0] m_cnt, m_sv, m_cv, m_val;
  logic [UPR_W-1:0] m_uc, m_cu, m_upr;
  logic             m_ce, m_en, m_pend;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= '0; m_sv <= '0; m_cv <= '0; m_val <= '0;
      m_uc <= '0; m_cu <= '0; m_upr <= '0;
      m_ce <= 1'b0; m_en <= 1'b0; m_pend <= 1'b0;
    end else begin
      automatic bit pe = (m_cnt >= period_i);
      automatic bit tp = pe && (m_uc == m_upr);
      m_cnt <= pe ? '0 : m_cnt + 1'b1;
      if (pe) m_uc <= tp ? '0 : m_uc + 1'b1;
      if (tp && m_pend) begin
        m_val <= m_cv; m_en <= m_ce; m_upr <= m_cu;
      end
      if (wr_en_i && !wr_sel_i) m_sv <= wr_data_i;
      if (wr_en_i && wr_sel_i) begin
        m_cv <= m_sv; m_ce <= wr_data_i[0]; m_cu <= wr_data_i[4:1]; m_pend <= 1'b1;
      end else if (tp) m_pend <= 1'b0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (live && rst_ni) begin
    check("R1 cnt", cnt_o, m_cnt);
    check("R1 period_end", period_end_o, m_cnt >= period_i);
    check("R5 upd_cnt", upd_cnt_o, m_uc);
    check("R3 cmp_val", cmp_val_o, m_val);
    check("R3 cmp_en", cmp_en_o, m_en);
    check("R4 match", match_o, m_en && (m_cnt == m_val));
    if (!m_en) check("R9 match off", match_o, 0);
  end

  task automatic wr(bit sel, logic [CNT_W-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [CNT_W-1:0] cfg(bit en, int upr);
    return CNT_W'((upr << 1) | en);
  endfunction

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #1;
    check("R10 cnt", cnt_o, 0);
    check("R10 upd", upd_cnt_o, 0);
    check("R10 val", cmp_val_o, 0);
    check("R10 en", cmp_en_o, 0);
    check("R10 match", match_o, 0);
    #10 rst_ni = 1'b1;
    live = 1'b1;
    run(12);                        // disabled, R9
    wr(0, 16'd2); wr(1, cfg(1, 0)); // R2 encoding
    run(12);
    check("R2 val applied", cmp_val_o, 2);
    check("R2 en applied", cmp_en_o, 1);
    wr(0, 16'd1);                   // value alone, R6
    run(20);
    check("R6 value-only ignored", cmp_val_o, 2);
    run(8);
    check("R8 no pending keeps val", cmp_val_o, 2);
    wr(1, cfg(1, 2));
    run(20);
    check("R6 committed by cfg", cmp_val_o, 1);
    wr(0, 16'd5); wr(0, 16'd0); wr(1, cfg(1, 1));
    wr(0, 16'd3); wr(1, cfg(1, 1));  // R7 last wins
    run(30);
    check("R7 last value", cmp_val_o, 3);
    for (int p = 1; p <= 4; p++) begin
      period_i = CNT_W'(p);
      for (int u = 0; u <= 3; u++) begin
        for (int v = 0; v <= p; v++) begin
          wr(0, CNT_W'(v)); wr(1, cfg(1, u));
          run((p + 1) * (u + 2) * 2 + 16);
          check("R3 sweep val", cmp_val_o, v);
        end
      end
    end
    wr(1, cfg(0, 0));               // disable, R9
    run(40);
    check("R9 disabled", cmp_en_o, 0);
    period_i = 16'd2;
    run(10);
    live = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R10 reset again cnt", cnt_o, 0);
    check("R10 reset again val", cmp_val_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule